// File: doc/BRIEF.md
# Memory-Resident Mutex Wait Queue

This block gives mutual exclusion over shared routines while keeping all of its state in ordinary memory. A lock is the address of a two-word block. The word at the lock address holds a busy flag and the head pointer of a waiter list. The word that follows it holds the tail pointer. A requester names the lock and gives the address of its own link word, which is a spare memory word placed right after its acquire word.

On an acquire, the block reads the head word. If the lock is free, it marks the lock busy and grants at once. If the lock is held, it adds the requester to the end of a singly linked FIFO that runs through the link words.

On a release, the first waiter is taken off the list and the lock stays busy. The response then carries that waiter's resume address, which is its link address plus one. If nobody is waiting, the head word is cleared. Requests are served strictly one after another, so every read-modify-write sequence on memory is atomic. The block drives a single-port memory whose read data returns one cycle after the read strobe.

Top module: `mtxq_top`

## Requirements
- R1: An acquire whose head word has the busy flag clear writes the head word with busy set and a null pointer of zero. It then responds with code GRANT (0) and with rsp_addr equal to the link address plus one.
- R2: An acquire whose head word has the busy flag set responds with code QUEUED (1) and rsp_addr 0. It also writes zero into the requester's link word, whatever that word held before.
- R3: When a lock is held and its head pointer is zero, an acquire writes the head word as busy plus the new link address, and writes the tail word (lock address plus one) with the new link address.
- R4: When a lock is held and its head pointer is non-zero, an acquire reads the tail word, writes the new link address into the link word that the old tail names, and then writes the tail word with the new link address.
- R5: A release whose head pointer is non-zero reads the link word of the head waiter and writes the head word as busy plus the pointer found there. It responds with code HANDOFF (3) and rsp_addr equal to the waiter's link address plus one. Waiters leave in the order they arrived.
- R6: A release whose head pointer is zero writes the head word as all zeros, which clears the busy flag. It responds with code FREED (2) and rsp_addr 0. This also holds for a lock that was never taken.
- R7: req_ready is high only while the block is idle. No new request is accepted while a sequence is in progress or a response is waiting.
- R8: Once raised, rsp_valid and its code and address stay unchanged until a cycle in which rsp_ready is high. rsp_valid falls on the clock edge after that cycle.
- R9: Word layout: the busy flag is bit WORD_W-1 of the head word. Pointers take the low ADDR_W bits of every word, and all other bits are written as zero. A memory word address is ADDR_W bits wide.
- R10: During and just after reset, req_ready is high, rsp_valid is low, and neither memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_release | input | 1 | 1 = release, 0 = acquire |
| req_lock | input | ADDR_W | Address of the lock's head word |
| req_link | input | ADDR_W | Requester's link word address (acquire only) |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 2 | 0 GRANT, 1 QUEUED, 2 FREED, 3 HANDOFF |
| rsp_addr | output | ADDR_W | Resume address for GRANT and HANDOFF, otherwise 0 |
| mem_rd | output | 1 | Memory read strobe; data valid on mem_rdata next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data |

## Verification
The assertions assume three things about the environment. The memory returns read data exactly one cycle after mem_rd. Nothing but this block writes the lock blocks or link words during a sequence. Callers use a lock's queue consistently, so a link word is never on two lists at once and no link address is zero. The stimulus keeps within these limits. The bench memory is a plain registered array that only the block writes while a request is open. Each requester gets its own distinct non-zero link address, and those addresses are placed apart from every lock block. The bench presets memory only while the block sits idle.

// File: rtl/mtxq_pkg.sv
package mtxq_pkg;
   typedef enum logic [1:0] {
      RSP_GRANT   = 2'd0,
      RSP_QUEUED  = 2'd1,
      RSP_FREED   = 2'd2,
      RSP_HANDOFF = 2'd3
   } rsp_code_e;

   typedef enum logic [3:0] {
      S_IDLE, S_RDHEAD, S_HEAD, S_SETHEAD, S_RDTAIL,
      S_TAIL, S_WRTAIL, S_NEXT, S_RESP
   } seq_state_e;
endpackage

// File: rtl/mtxq_word_fmt.sv
module mtxq_word_fmt #(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 8
) (
   input  logic              enc_busy,
   input  logic [ADDR_W-1:0] enc_ptr,
   output logic [WORD_W-1:0] enc_word,
   input  logic [WORD_W-1:0] dec_word,
   output logic              dec_busy,
   output logic [ADDR_W-1:0] dec_ptr
);
   localparam int PAD_W = WORD_W - ADDR_W - 1;

   generate
      if (PAD_W < 0) begin : g_bad
         $error("mtxq_word_fmt: WORD_W must exceed ADDR_W");
      end else if (PAD_W == 0) begin : g_tight
         assign enc_word = {enc_busy, enc_ptr};
      end else begin : g_padded
         assign enc_word = {enc_busy, {PAD_W{1'b0}}, enc_ptr};
      end
   endgenerate

   assign dec_busy = dec_word[WORD_W-1];
   assign dec_ptr  = dec_word[ADDR_W-1:0];
endmodule

// File: rtl/mtxq_req_cap.sv
module mtxq_req_cap #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              in_release,
   input  logic [ADDR_W-1:0] in_lock,
   input  logic [ADDR_W-1:0] in_link,
   output logic              q_release,
   output logic [ADDR_W-1:0] q_lock,
   output logic [ADDR_W-1:0] q_link
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_release <= 1'b0;
         q_lock    <= '0;
         q_link    <= '0;
      end else if (take) begin
         q_release <= in_release;
         q_lock    <= in_lock;
         q_link    <= in_link;
      end
   end
endmodule

// File: rtl/mtxq_seq.sv
module mtxq_seq
   import mtxq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_rel,
   input  logic [ADDR_W-1:0] lock_a,
   input  logic [ADDR_W-1:0] link_a,
   input  logic              rd_busy,
   input  logic [ADDR_W-1:0] rd_ptr,
   output logic              idle,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              wr_busy,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_code,
   output logic [ADDR_W-1:0] rsp_addr
);
   localparam logic [ADDR_W-1:0] NULL_P = '0;
   localparam logic [ADDR_W-1:0] ONE_P  = ADDR_W'(1);

   seq_state_e st, nxt;

   always_comb begin
      nxt      = st;
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      mem_addr = lock_a;
      wr_busy  = 1'b0;
      wr_ptr   = NULL_P;
      unique case (st)
         S_IDLE:   if (start) nxt = S_RDHEAD;
         S_RDHEAD: begin mem_rd = 1'b1; nxt = S_HEAD; end
         S_HEAD: begin
            if (!op_rel) begin
               mem_wr = 1'b1;
               if (!rd_busy) begin
                  wr_busy = 1'b1;
                  nxt     = S_RESP;
               end else begin
                  mem_addr = link_a;
                  nxt      = (rd_ptr == NULL_P) ? S_SETHEAD : S_RDTAIL;
               end
            end else if (rd_ptr == NULL_P) begin
               mem_wr = 1'b1;
               nxt    = S_RESP;
            end else begin
               mem_rd   = 1'b1;
               mem_addr = rd_ptr;
               nxt      = S_NEXT;
            end
         end
         S_SETHEAD: begin
            mem_wr = 1'b1; wr_busy = 1'b1; wr_ptr = link_a; nxt = S_WRTAIL;
         end
         S_RDTAIL: begin
            mem_rd = 1'b1; mem_addr = lock_a + ONE_P; nxt = S_TAIL;
         end
         S_TAIL: begin
            mem_wr = 1'b1; mem_addr = rd_ptr; wr_ptr = link_a; nxt = S_WRTAIL;
         end
         S_WRTAIL: begin
            mem_wr = 1'b1; mem_addr = lock_a + ONE_P; wr_ptr = link_a; nxt = S_RESP;
         end
         S_NEXT: begin
            mem_wr = 1'b1; wr_busy = 1'b1; wr_ptr = rd_ptr; nxt = S_RESP;
         end
         S_RESP:   if (rsp_ready) nxt = S_IDLE;
         default:  nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         rsp_code <= RSP_GRANT;
         rsp_addr <= NULL_P;
      end else begin
         st <= nxt;
         if (st == S_HEAD) begin
            if (!op_rel && !rd_busy) begin
               rsp_code <= RSP_GRANT;   rsp_addr <= link_a + ONE_P;
            end else if (!op_rel) begin
               rsp_code <= RSP_QUEUED;  rsp_addr <= NULL_P;
            end else if (rd_ptr == NULL_P) begin
               rsp_code <= RSP_FREED;   rsp_addr <= NULL_P;
            end else begin
               rsp_code <= RSP_HANDOFF; rsp_addr <= rd_ptr + ONE_P;
            end
         end
      end
   end

   assign idle      = (st == S_IDLE);
   assign rsp_valid = (st == S_RESP);

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R7
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_addr)); // R8
   AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) && rsp_code == RSP_GRANT |-> $past(mem_wr) && $past(wr_busy)
      && $past(wr_ptr) == NULL_P && $past(mem_addr) == lock_a); // R1
   AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) && rsp_code == RSP_FREED |-> $past(mem_wr) && !$past(wr_busy)
      && $past(wr_ptr) == NULL_P); // R6
   AST_HANDOFF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) && rsp_code == RSP_HANDOFF |-> $past(mem_wr) && $past(wr_busy)
      && $past(mem_addr) == lock_a && rsp_addr != NULL_P); // R5
   AST_QUEUE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) && rsp_code == RSP_QUEUED |-> $past(mem_wr)
      && $past(mem_addr) == lock_a + ONE_P && $past(wr_ptr) == link_a); // R3
endmodule

// File: rtl/mtxq_top.sv
module mtxq_top #(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_release,
   input  logic [ADDR_W-1:0] req_lock,
   input  logic [ADDR_W-1:0] req_link,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_code,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata
);
   generate
      if (ADDR_W < 2) begin : g_chk_addr
         $error("mtxq_top: ADDR_W must be at least 2");
      end
      if (WORD_W < ADDR_W + 1) begin : g_chk_word
         $error("mtxq_top: WORD_W must hold a pointer and the busy flag");
      end
   endgenerate

   logic              take, q_rel, rd_busy, wr_busy, idle;
   logic [ADDR_W-1:0] q_lock, q_link, rd_ptr, wr_ptr;

   assign req_ready = idle;
   assign take      = req_valid && idle;

   mtxq_req_cap #(.ADDR_W(ADDR_W)) cap_i (
      .clk(clk), .rst_n(rst_n), .take(take),
      .in_release(req_release), .in_lock(req_lock), .in_link(req_link),
      .q_release(q_rel), .q_lock(q_lock), .q_link(q_link)
   );

   mtxq_word_fmt #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) fmt_i (
      .enc_busy(wr_busy), .enc_ptr(wr_ptr), .enc_word(mem_wdata),
      .dec_word(mem_rdata), .dec_busy(rd_busy), .dec_ptr(rd_ptr)
   );

   mtxq_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(take), .op_rel(q_rel),
      .lock_a(q_lock), .link_a(q_link), .rd_busy(rd_busy), .rd_ptr(rd_ptr),
      .idle(idle), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .wr_busy(wr_busy), .wr_ptr(wr_ptr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_code(rsp_code), .rsp_addr(rsp_addr)
   );

   AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !mem_rd && !mem_wr); // R7
   AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R7
endmodule

// File: tb/mtxq_top_tb_top.sv
module mtxq_top_tb_top;
   localparam int WORD_W = 24;
   localparam int ADDR_W = 8;
   localparam int NVEC   = 14;
   localparam logic [WORD_W-1:0] BUSY = {1'b1, {(WORD_W-1){1'b0}}};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_release = 1'b0, rsp_ready = 1'b0;
   logic [ADDR_W-1:0] req_lock = '0, req_link = '0;
   logic              req_ready, rsp_valid, mem_rd, mem_wr;
   logic [1:0]        rsp_code;
   logic [ADDR_W-1:0] rsp_addr, mem_addr;
   logic [WORD_W-1:0] mem_wdata, mem_rdata;
   logic [WORD_W-1:0] mem [1 << ADDR_W];

   int n_tests = 0, n_fail = 0, cyc = 0;
   logic [1:0]        got_code;
   logic [ADDR_W-1:0] got_addr;

   always #5 clk = ~clk;

   mtxq_top #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_release(req_release), .req_lock(req_lock), .req_link(req_link),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
      .rsp_addr(rsp_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   // vector: {release, lock, link, code, addr}
   localparam logic [26:0] VEC [NVEC] = '{
      {1'b0, 8'h10, 8'h20, 2'd0, 8'h21},
      {1'b0, 8'h10, 8'h40, 2'd1, 8'h00},
      {1'b0, 8'h18, 8'h80, 2'd0, 8'h81},
      {1'b0, 8'h10, 8'h50, 2'd1, 8'h00},
      {1'b0, 8'h18, 8'h90, 2'd1, 8'h00},
      {1'b1, 8'h10, 8'h00, 2'd3, 8'h41},
      {1'b0, 8'h10, 8'h60, 2'd1, 8'h00},
      {1'b1, 8'h18, 8'h00, 2'd3, 8'h91},
      {1'b1, 8'h10, 8'h00, 2'd3, 8'h51},
      {1'b1, 8'h10, 8'h00, 2'd3, 8'h61},
      {1'b1, 8'h10, 8'h00, 2'd2, 8'h00},
      {1'b1, 8'h18, 8'h00, 2'd2, 8'h00},
      {1'b0, 8'h10, 8'h70, 2'd0, 8'h71},
      {1'b1, 8'h10, 8'h00, 2'd2, 8'h00}
   };

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic run_req(input logic rel, input logic [ADDR_W-1:0] lk,
                          input logic [ADDR_W-1:0] ln, input int hold);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_release = rel; req_lock = lk; req_link = ln;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      got_code = rsp_code; got_addr = rsp_addr;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check(rsp_valid && rsp_code == got_code && rsp_addr == got_addr,
               "R8 response held", {rsp_valid, rsp_code, rsp_addr}, {1'b1, got_code, got_addr});
         check(!req_ready, "R7 no accept while response pending", req_ready, 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(!rsp_valid, "R8 rsp_valid drops after take", rsp_valid, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(req_ready && !rsp_valid && !mem_rd && !mem_wr, "R10 reset state",
            {req_ready, rsp_valid, mem_rd, mem_wr}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_rd && !mem_wr, "R10 after reset",
            {req_ready, rsp_valid, mem_rd, mem_wr}, 4'b1000);

      // table walk: R1 R2 R5 R6 with FIFO order across two locks
      for (int v = 0; v < NVEC; v++) begin
         run_req(VEC[v][26], VEC[v][25:18], VEC[v][17:10], 0);
         check(got_code == VEC[v][9:8] && got_addr == VEC[v][7:0],
               $sformatf("R5 R1 R2 R6 vector %0d", v), {got_code, got_addr}, VEC[v][9:0]);
      end
      check(mem[8'h10] == '0, "R6 lock A freed word", mem[8'h10], 0);

      // directed on lock 0x30
      run_req(1'b0, 8'h30, 8'hA0, 0);
      check(got_code == 2'd0 && got_addr == 8'hA1, "R1 grant", {got_code, got_addr}, {2'd0, 8'hA1});
      check(mem[8'h30] == BUSY, "R1 R9 head busy null", mem[8'h30], BUSY);
      run_req(1'b0, 8'h30, 8'hB0, 0);
      check(mem[8'h30] == (BUSY | 24'hB0), "R3 head gets link", mem[8'h30], BUSY | 24'hB0);
      check(mem[8'h31] == 24'hB0, "R3 tail gets link", mem[8'h31], 24'hB0);
      mem[8'hC0] = 24'h55AA55;
      run_req(1'b0, 8'h30, 8'hC0, 0);
      check(got_code == 2'd1 && got_addr == 0, "R2 queued", {got_code, got_addr}, {2'd1, 8'h00});
      check(mem[8'hC0] == '0, "R2 link word cleared", mem[8'hC0], 0);
      check(mem[8'hB0] == 24'hC0, "R4 old tail links new", mem[8'hB0], 24'hC0);
      check(mem[8'h31] == 24'hC0, "R4 tail updated", mem[8'h31], 24'hC0);
      check(mem[8'h30] == (BUSY | 24'hB0), "R4 head unchanged", mem[8'h30], BUSY | 24'hB0);
      run_req(1'b1, 8'h30, 8'h00, 0);
      check(got_code == 2'd3 && got_addr == 8'hB1, "R5 handoff first", {got_code, got_addr}, {2'd3, 8'hB1});
      check(mem[8'h30] == (BUSY | 24'hC0), "R5 head advances busy", mem[8'h30], BUSY | 24'hC0);
      run_req(1'b1, 8'h30, 8'h00, 3);
      check(got_code == 2'd3 && got_addr == 8'hC1, "R5 R8 handoff held", {got_code, got_addr}, {2'd3, 8'hC1});
      check(mem[8'h30] == BUSY, "R5 last waiter leaves null head", mem[8'h30], BUSY);
      run_req(1'b1, 8'h30, 8'h00, 0);
      check(got_code == 2'd2 && got_addr == 0, "R6 freed", {got_code, got_addr}, {2'd2, 8'h00});
      check(mem[8'h30] == '0, "R6 head cleared", mem[8'h30], 0);
      run_req(1'b1, 8'h38, 8'h00, 0);
      check(got_code == 2'd2 && mem[8'h38] == '0, "R6 release of free lock",
            {got_code, mem[8'h38]}, {2'd2, 24'h0});
      // R9 re-acquire after free grants
      run_req(1'b0, 8'h30, 8'hD0, 0);
      check(got_code == 2'd0 && got_addr == 8'hD1, "R9 R1 regrant", {got_code, got_addr}, {2'd0, 8'hD1});

      finish_run();
   end
endmodule